// File: doc/BRIEF.md
# Coherent split-word output register

This block holds the latest sensor results (a 24-bit pressure value, a 16-bit temperature value and a 16-bit delta-pressure value) and serves them one byte per read to a byte-wide register port. Each value occupies consecutive byte addresses. One control bit chooses which end of that address range carries the most significant byte. The bus that issues the reads, the sample producer and the delta arithmetic are outside the block.

When the block-data-update control is set, a value can never be read back with bytes from two different samples. A read of either end byte of a value freezes that value. While it is frozen, new samples for it are dropped. A read of the opposite end byte releases it. Each value keeps its own freeze state. The block also passes the delta-computation enable out as a register output that resets to 0.

Top module: `swo_out_regs`

## Requirements
- R1: After reset, all three stored values are zero, no value is frozen, `rd_data_o` is 0x00 and `delta_en_o` is 0.
- R2: With `bdu_i` = 0, every strobed sample (`*_vld_i` = 1) is stored on that clock edge, and a later read returns bytes of the newest sample.
- R3: With `bdu_i` = 1, a read of the lowest address of a value (pressure 0x20, temperature 0x24, delta 0x26) freezes that value. Samples for it are dropped until its highest address (pressure 0x22, temperature 0x25, delta 0x27) has been read.
- R4: The freeze is symmetric. With `bdu_i` = 1, reading the highest address first freezes the value until the lowest address is read.
- R5: With `bdu_i` = 1, a sample that arrives in the same cycle as either the freezing read or the releasing read is dropped. The first sample after the releasing cycle is stored.
- R6: Reading the pressure middle byte (0x21) neither freezes nor releases pressure.
- R7: Freeze state is kept per value. A frozen value does not block samples for the other values, and reads of one value do not release another.
- R8: With `big_endian_i` = 0, the lowest address of each value returns bits [7:0] and higher addresses return more significant bytes. With `big_endian_i` = 1, the lowest address returns the most significant byte and the highest address returns bits [7:0]. The pressure middle byte is bits [15:8] in both orders. This applies to all three values.
- R9: A read of an address outside 0x20–0x22 and 0x24–0x27 returns 0x00 and leaves every freeze state unchanged.
- R10: `delta_en_o` equals `diff_en_i` delayed by one clock.
- R11: `rd_data_o` presents the addressed byte one clock after the cycle in which `rd_en_i` is 1, and keeps it while `rd_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bdu_i | input | 1 | Block-data-update mode: 1 enables freezing |
| big_endian_i | input | 1 | Byte order: 1 places the MSB at the lowest address |
| diff_en_i | input | 1 | Delta computation enable request |
| prs_vld_i | input | 1 | New pressure sample strobe |
| prs_data_i | input | 24 | Pressure sample |
| tmp_vld_i | input | 1 | New temperature sample strobe |
| tmp_data_i | input | 16 | Temperature sample |
| dlt_vld_i | input | 1 | New delta-pressure sample strobe |
| dlt_data_i | input | 16 | Delta-pressure sample |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Read data, one clock after the strobe |
| delta_en_o | output | 1 | Registered delta computation enable |

## Verification
Samples go in with freezing off, and then under both byte orders, so that a wrong lane mapping shows up as a swapped byte at a known address. With freezing on, the bench reads low-end-first and high-end-first, adds samples between the two halves, and puts samples in the same cycle as the freezing read and as the releasing read. A captured sample changes a later read and a dropped one does not, so each of these orderings separates the two outcomes. Middle-byte reads, interleaved accesses to other values, repeated same-end reads and unmapped reads test which accesses may change the freeze state.

// File: rtl/swo_pkg.sv
package swo_pkg;
   typedef logic [7:0] byte_t;

   // Byte of the stored value shown at address offset k of an nb-byte value.
   function automatic int unsigned lane_of(input int unsigned k, input int unsigned nb,
                                           input logic big);
      return big ? (nb - 1 - k) : k;
   endfunction
endpackage

// File: rtl/swo_slot.sv
module swo_slot
   import swo_pkg::*;
#(
   parameter int unsigned NB     = 2,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned BASE   = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bdu_i,
   input  logic              big_i,
   input  logic              smp_vld_i,
   input  logic [NB*8-1:0]   smp_dat_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic              hit_o,
   output byte_t             byte_o,
   output logic [NB*8-1:0]   val_o,
   output logic              frz_o
);
   localparam int unsigned W = NB * 8;
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(BASE + NB - 1);

   initial begin
      if (NB < 2) $error("swo_slot: NB must be at least 2");
      if (BASE + NB > (1 << ADDR_W)) $error("swo_slot: range exceeds address space");
   end

   logic [W-1:0] val_q;
   logic         seen_lo_q, seen_hi_q;
   logic         end_lo, end_hi, hold, cap;
   byte_t        lane [NB];

   assign end_lo = rd_en_i && (rd_addr_i == BASE_A);
   assign end_hi = rd_en_i && (rd_addr_i == LAST_A);
   assign frz_o  = seen_lo_q | seen_hi_q;
   assign hold   = bdu_i && (frz_o || end_lo || end_hi);
   assign cap    = smp_vld_i && !hold;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         val_q <= '0;
      end else if (cap) begin
         val_q <= smp_dat_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         seen_lo_q <= 1'b0;
         seen_hi_q <= 1'b0;
      end else if (!bdu_i) begin
         seen_lo_q <= 1'b0;
         seen_hi_q <= 1'b0;
      end else if ((seen_lo_q | end_lo) && (seen_hi_q | end_hi)) begin
         seen_lo_q <= 1'b0;
         seen_hi_q <= 1'b0;
      end else begin
         seen_lo_q <= seen_lo_q | end_lo;
         seen_hi_q <= seen_hi_q | end_hi;
      end
   end

   for (genvar k = 0; k < NB; k++) begin : g_lane
      localparam int unsigned LE = lane_of(k, NB, 1'b0);
      localparam int unsigned BE = lane_of(k, NB, 1'b1);
      assign lane[k] = big_i ? val_q[BE*8 +: 8] : val_q[LE*8 +: 8];
   end

   assign hit_o = (rd_addr_i >= BASE_A) && (rd_addr_i <= LAST_A);

   always_comb begin
      byte_o = '0;
      for (int k = 0; k < NB; k++) begin
         if (rd_addr_i == BASE_A + ADDR_W'(k)) byte_o = lane[k];
      end
   end

   assign val_o = val_q;
endmodule

// File: rtl/swo_rdmux.sv
module swo_rdmux
   import swo_pkg::*;
#(
   parameter int unsigned N = 3
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         rd_en_i,
   input  logic [N-1:0] hit_i,
   input  logic [N*8-1:0] bytes_i,
   output byte_t        rd_data_o
);
   initial begin
      if (N < 1) $error("swo_rdmux: N must be at least 1");
   end

   byte_t sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < N; i++) begin
         if (hit_i[i]) sel = sel | bytes_i[i*8 +: 8];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_data_o <= '0;
      end else if (rd_en_i) begin
         rd_data_o <= sel;
      end
   end
endmodule

// File: rtl/swo_out_regs.sv
module swo_out_regs
   import swo_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned PRS_BYTES = 3,
   parameter int unsigned TMP_BYTES = 2,
   parameter int unsigned DLT_BYTES = 2,
   parameter int unsigned PRS_BASE  = 32,
   parameter int unsigned TMP_BASE  = 36,
   parameter int unsigned DLT_BASE  = 38
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   bdu_i,
   input  logic                   big_endian_i,
   input  logic                   diff_en_i,
   input  logic                   prs_vld_i,
   input  logic [PRS_BYTES*8-1:0] prs_data_i,
   input  logic                   tmp_vld_i,
   input  logic [TMP_BYTES*8-1:0] tmp_data_i,
   input  logic                   dlt_vld_i,
   input  logic [DLT_BYTES*8-1:0] dlt_data_i,
   input  logic                   rd_en_i,
   input  logic [ADDR_W-1:0]      rd_addr_i,
   output logic [7:0]             rd_data_o,
   output logic                   delta_en_o
);
   localparam int unsigned NSLOT = 3;

   initial begin
      if (PRS_BASE + PRS_BYTES > TMP_BASE) $error("swo_out_regs: pressure overlaps temperature");
      if (TMP_BASE + TMP_BYTES > DLT_BASE) $error("swo_out_regs: temperature overlaps delta");
   end

   logic [NSLOT-1:0]      hit;
   logic [NSLOT*8-1:0]    bytes;
   logic [PRS_BYTES*8-1:0] prs_val;
   logic [TMP_BYTES*8-1:0] tmp_val;
   logic [DLT_BYTES*8-1:0] dlt_val;
   logic                   prs_frz, tmp_frz, dlt_frz;

   swo_slot #(.NB(PRS_BYTES), .ADDR_W(ADDR_W), .BASE(PRS_BASE)) u_prs (
      .clk_i, .rst_ni, .bdu_i, .big_i(big_endian_i),
      .smp_vld_i(prs_vld_i), .smp_dat_i(prs_data_i),
      .rd_en_i, .rd_addr_i,
      .hit_o(hit[0]), .byte_o(bytes[0 +: 8]), .val_o(prs_val), .frz_o(prs_frz));

   swo_slot #(.NB(TMP_BYTES), .ADDR_W(ADDR_W), .BASE(TMP_BASE)) u_tmp (
      .clk_i, .rst_ni, .bdu_i, .big_i(big_endian_i),
      .smp_vld_i(tmp_vld_i), .smp_dat_i(tmp_data_i),
      .rd_en_i, .rd_addr_i,
      .hit_o(hit[1]), .byte_o(bytes[8 +: 8]), .val_o(tmp_val), .frz_o(tmp_frz));

   swo_slot #(.NB(DLT_BYTES), .ADDR_W(ADDR_W), .BASE(DLT_BASE)) u_dlt (
      .clk_i, .rst_ni, .bdu_i, .big_i(big_endian_i),
      .smp_vld_i(dlt_vld_i), .smp_dat_i(dlt_data_i),
      .rd_en_i, .rd_addr_i,
      .hit_o(hit[2]), .byte_o(bytes[16 +: 8]), .val_o(dlt_val), .frz_o(dlt_frz));

   swo_rdmux #(.N(NSLOT)) u_mux (
      .clk_i, .rst_ni, .rd_en_i, .hit_i(hit), .bytes_i(bytes), .rd_data_o);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         delta_en_o <= 1'b0;
      end else begin
         delta_en_o <= diff_en_i;
      end
   end
endmodule

module swo_out_regs_chk #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned PRS_BYTES = 3,
   parameter int unsigned TMP_BYTES = 2,
   parameter int unsigned DLT_BYTES = 2,
   parameter int unsigned PRS_BASE  = 32,
   parameter int unsigned TMP_BASE  = 36,
   parameter int unsigned DLT_BASE  = 38
) (
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic                   bdu_i,
   input logic                   diff_en_i,
   input logic                   tmp_vld_i,
   input logic [TMP_BYTES*8-1:0] tmp_data_i,
   input logic                   rd_en_i,
   input logic [ADDR_W-1:0]      rd_addr_i,
   input logic [7:0]             rd_data_o,
   input logic                   delta_en_o,
   input logic [PRS_BYTES*8-1:0] prs_val,
   input logic [TMP_BYTES*8-1:0] tmp_val,
   input logic [DLT_BYTES*8-1:0] dlt_val,
   input logic                   prs_frz,
   input logic                   tmp_frz,
   input logic                   dlt_frz
);
   logic in_map;
   assign in_map = (32'(rd_addr_i) >= PRS_BASE && 32'(rd_addr_i) < PRS_BASE + PRS_BYTES)
                || (32'(rd_addr_i) >= TMP_BASE && 32'(rd_addr_i) < TMP_BASE + TMP_BYTES)
                || (32'(rd_addr_i) >= DLT_BASE && 32'(rd_addr_i) < DLT_BASE + DLT_BYTES);

   // R3
   prs_frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bdu_i && prs_frz) |=> $stable(prs_val));
   // R4
   tmp_frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bdu_i && tmp_frz) |=> $stable(tmp_val));
   // R7
   dlt_frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bdu_i && dlt_frz) |=> $stable(dlt_val));
   // R2
   tmp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!bdu_i && tmp_vld_i) |=> (tmp_val == $past(tmp_data_i)));
   // R9
   unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && !in_map) |=> (rd_data_o == 8'h00));
   // R9
   unmapped_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && !in_map && bdu_i) |=> ($stable(prs_frz) && $stable(tmp_frz) && $stable(dlt_frz)));
   // R10
   delta_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (delta_en_o == $past(diff_en_i)));
   // R11
   rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> $stable(rd_data_o));
endmodule

bind swo_out_regs swo_out_regs_chk #(
   .ADDR_W(ADDR_W), .PRS_BYTES(PRS_BYTES), .TMP_BYTES(TMP_BYTES), .DLT_BYTES(DLT_BYTES),
   .PRS_BASE(PRS_BASE), .TMP_BASE(TMP_BASE), .DLT_BASE(DLT_BASE)
) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .bdu_i(bdu_i), .diff_en_i(diff_en_i),
   .tmp_vld_i(tmp_vld_i), .tmp_data_i(tmp_data_i),
   .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .delta_en_o(delta_en_o),
   .prs_val(prs_val), .tmp_val(tmp_val), .dlt_val(dlt_val),
   .prs_frz(prs_frz), .tmp_frz(tmp_frz), .dlt_frz(dlt_frz));

// File: tb/test_swo_out_regs.sv
module test_swo_out_regs;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        bdu_i = 1'b0, big_endian_i = 1'b0, diff_en_i = 1'b0;
   logic        prs_vld_i = 1'b0, tmp_vld_i = 1'b0, dlt_vld_i = 1'b0;
   logic [23:0] prs_data_i = '0;
   logic [15:0] tmp_data_i = '0, dlt_data_i = '0;
   logic        rd_en_i = 1'b0;
   logic [7:0]  rd_addr_i = '0;
   logic [7:0]  rd_data_o;
   logic        delta_en_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic       mon_due = 1'b0;

   always #2 clk_i = ~clk_i;

   swo_out_regs i_swo_out_regs (.*);

   always @(posedge clk_i) mon_due <= rd_en_i;

   // monitor: pops one expected byte per completed read
   always @(negedge clk_i) begin
      if (mon_due && exp_q.size() > 0) begin
         logic [7:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         total++;
         if (rd_data_o !== e) begin
            bad++;
            $display("FAIL %s: rd_data actual=%02h expected=%02h", t, rd_data_o, e);
         end
      end
   end

   task automatic chk(input string t, input logic [7:0] act, input logic [7:0] e);
      total++;
      if (act !== e) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", t, act, e);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk_i);
   endtask

   // drives one read cycle and optionally one sample of a kind (0 none, 1 prs, 2 tmp, 3 dlt)
   task automatic drive(input logic rd, input logic [7:0] a, input logic [7:0] e, input string t,
                        input int kind, input logic [23:0] d);
      if (rd) begin
         rd_en_i = 1'b1; rd_addr_i = a;
         exp_q.push_back(e); tag_q.push_back(t);
      end
      case (kind)
         1: begin prs_vld_i = 1'b1; prs_data_i = d; end
         2: begin tmp_vld_i = 1'b1; tmp_data_i = d[15:0]; end
         3: begin dlt_vld_i = 1'b1; dlt_data_i = d[15:0]; end
         default: ;
      endcase
      @(negedge clk_i);
      rd_en_i = 1'b0; prs_vld_i = 1'b0; tmp_vld_i = 1'b0; dlt_vld_i = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
      drive(1'b1, a, e, t, 0, '0);
   endtask

   task automatic smp(input int kind, input logic [23:0] d);
      drive(1'b0, '0, '0, "", kind, d);
   endtask

   initial begin
      repeat (20000) @(posedge clk_i);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_ni = 1'b1;
      idle(1);
      // R1 reset state
      chk("R1 rdata", rd_data_o, 8'h00);
      chk("R1 delta_en", {7'b0, delta_en_o}, 8'h00);
      rd(8'h20, 8'h00, "R1 prs");
      rd(8'h25, 8'h00, "R1 tmp");
      rd(8'h27, 8'h00, "R1 dlt");

      // R2 continuous update, little endian
      smp(1, 24'h123456);
      rd(8'h20, 8'h56, "R2 p lo");
      rd(8'h21, 8'h34, "R2 p mid");
      rd(8'h22, 8'h12, "R2 p hi");
      smp(1, 24'hABCDEF);
      rd(8'h22, 8'hAB, "R2 p newest");
      smp(2, 24'h00BEEF);
      rd(8'h24, 8'hEF, "R2 t lo");
      drive(1'b1, 8'h25, 8'hBE, "R2 t hi", 2, 24'h00CAFE);
      rd(8'h25, 8'hCA, "R2 t newest");
      smp(2, 24'h00BEEF);

      // R8 big endian, all three values
      big_endian_i = 1'b1;
      rd(8'h20, 8'hAB, "R8 p lo big");
      rd(8'h21, 8'hCD, "R8 p mid big");
      rd(8'h22, 8'hEF, "R8 p hi big");
      rd(8'h24, 8'hBE, "R8 t lo big");
      rd(8'h25, 8'hEF, "R8 t hi big");
      smp(3, 24'h001357);
      rd(8'h26, 8'h13, "R8 d lo big");
      rd(8'h27, 8'h57, "R8 d hi big");
      big_endian_i = 1'b0;
      rd(8'h26, 8'h57, "R8 d lo little");
      rd(8'h27, 8'h13, "R8 d hi little");

      // R3 low end first freezes
      bdu_i = 1'b1;
      rd(8'h24, 8'hEF, "R3 t lo");
      smp(2, 24'h001111);
      rd(8'h25, 8'hBE, "R3 t hi after drop");
      smp(2, 24'h002222);
      rd(8'h24, 8'h22, "R3 captured after release");
      rd(8'h25, 8'h22, "R3 release");

      // R4 high end first
      rd(8'h25, 8'h22, "R4 t hi first");
      smp(2, 24'h003333);
      rd(8'h24, 8'h22, "R4 t lo after drop");
      smp(2, 24'h004444);
      rd(8'h24, 8'h44, "R4 new lo");
      rd(8'h25, 8'h44, "R4 new hi");

      // R5 same-cycle samples
      rd(8'h24, 8'h44, "R5 freeze");
      drive(1'b1, 8'h25, 8'h44, "R5 release with sample", 2, 24'h005555);
      rd(8'h24, 8'h44, "R5 sample at release dropped");
      rd(8'h25, 8'h44, "R5 release 2");
      drive(1'b1, 8'h24, 8'h44, "R5 freeze with sample", 2, 24'h006666);
      rd(8'h25, 8'h44, "R5 sample at freeze dropped");
      smp(2, 24'h007777);
      rd(8'h24, 8'h77, "R5 next sample lo");
      rd(8'h25, 8'h77, "R5 next sample hi");

      // R6 pressure middle byte
      rd(8'h21, 8'hCD, "R6 mid");
      smp(1, 24'h010203);
      rd(8'h21, 8'h02, "R6 mid no freeze");
      rd(8'h20, 8'h03, "R6 lo freeze");
      rd(8'h21, 8'h02, "R6 mid while frozen");
      smp(1, 24'h0A0B0C);
      rd(8'h21, 8'h02, "R6 mid no release");
      rd(8'h22, 8'h01, "R6 hi release");
      smp(1, 24'h0A0B0C);
      rd(8'h22, 8'h0A, "R6 hi new");
      rd(8'h20, 8'h0C, "R6 lo new");

      // R7 independence
      rd(8'h24, 8'h77, "R7 t freeze");
      smp(1, 24'h111213);
      rd(8'h20, 8'h13, "R7 p captured");
      rd(8'h22, 8'h11, "R7 p release");
      smp(3, 24'h002468);
      rd(8'h26, 8'h68, "R7 d lo");
      rd(8'h27, 8'h24, "R7 d hi");
      smp(2, 24'h008888);
      rd(8'h25, 8'h77, "R7 t still frozen");

      // R9 unmapped
      rd(8'h24, 8'h77, "R9 t freeze");
      rd(8'h30, 8'h00, "R9 unmapped 30");
      rd(8'h23, 8'h00, "R9 unmapped 23");
      rd(8'h24, 8'h77, "R9 same side again");
      smp(2, 24'h009999);
      rd(8'h25, 8'h77, "R9 freeze kept");

      // R11 hold
      idle(3);
      chk("R11 hold", rd_data_o, 8'h77);

      // R10 delta enable
      diff_en_i = 1'b1;
      chk("R10 before edge", {7'b0, delta_en_o}, 8'h00);
      idle(1);
      chk("R10 set", {7'b0, delta_en_o}, 8'h01);
      diff_en_i = 1'b0;
      idle(1);
      chk("R10 clear", {7'b0, delta_en_o}, 8'h00);

      idle(2);
      if (exp_q.size() != 0) chk("R11 pending reads", 8'(exp_q.size()), 8'h00);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule